// File: doc/BRIEF.md
# Extended Interrupt Routing Controller

This block gathers a parameterised set of level-sensitive interrupt inputs and steers each one to a single CPU core and to one of four interrupt pins on that core. Every input has a raw pending bit that tracks its level. It also has an enable bit, a core route and a pin group. The pin group is shared by each block of 32 inputs. Each core has its own in-service vector. An output line exists for every core and pin pair. That line is high while any in-service interrupt belongs to that pair.

Software reaches the block through a single-cycle 32-bit word access port. Each access carries a requester core index. The word address picks a region. Enable, raw pending and in-service words each hold 32 interrupts, with bit n of word w standing for interrupt 32w+n. Pin-group and core-route words hold four byte fields, with byte k of word w describing item 4w+k. Enabling, masking, clearing and re-routing take effect at once on any interrupt that is already pending. Read data is registered and is valid one cycle after the access.

Word address map (8-bit word index): 0x00 mode word (bit 0 selects direct core numbering), 0x08 enable words, 0x10 pin-group words, 0x18 spare routing words, 0x20 four node-type words, 0x28 in-service words, 0x30 raw pending words (read only), 0x40 core-route words.

Top module: `extirq_router`

## Requirements
- R1: Raw pending bit n of raw word w follows input 32w+n one clock after the input changes, whether or not the interrupt is enabled.
- R2: A rising input whose enable bit is 0 changes no in-service bit and no output line.
- R3: A rising enabled input sets its bit in the in-service vector of its routed core on the next clock. The output line at index 4*core+pin rises one clock after that, where pin is the pin group of the input's 32-block.
- R4: An output line is high while at least one in-service interrupt routed to that core and pin remains. It falls only once the last one is removed, for example when its input falls.
- R5: Writing an enable word raises every interrupt whose bit goes 0 to 1 while its raw pending bit is set. It removes every in-service interrupt whose bit goes 1 to 0.
- R6: Writing ones to an in-service word clears those bits only in the vector of the core given as requester. Bits written as 0, and other cores' vectors, keep their values.
- R7: A pin-group byte selects the pin equal to its lowest set bit position. A byte whose lowest set bit is at position 4 or above, or a zero byte, selects pin 0. The outputs follow the current pin-group bytes.
- R8: With direct numbering off (mode bit 0 = 0), a core-route byte selects the core equal to its lowest set bit position, and a position of 4 or above, or a zero byte, selects core 0. With direct numbering on, the byte value itself is the core index.
- R9: A core-route byte that selects a core index of NUM_CORE or above leaves that interrupt's route unchanged.
- R10: When the route of a pending, enabled interrupt changes, its in-service bit and output move from the old core to the new core in the same update.
- R11: Reset clears all registers, routes every interrupt to core 0 and pin 0, and drives every output line and the read data low.
- R12: Spare routing words, node-type words, core-route words and the mode bit read back what was last written and have no effect on the outputs beyond the decoding in R7 to R10.
- R13: A read of an in-service word returns the vector of the requester core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IRQ | Level interrupt inputs |
| acc_en | input | 1 | Register access valid this cycle |
| acc_we | input | 1 | 1 for write, 0 for read |
| acc_addr | input | 8 | Word address |
| acc_wdata | input | 32 | Write data |
| acc_core | input | 8 | Index of the core issuing the access |
| acc_rdata | output | 32 | Read data, valid the cycle after a read |
| core_irq | output | 4*NUM_CORE | Output line for core c, pin p at bit 4c+p |

## Verification
The assertions assume that irq_in is synchronous to clk and that an input does not pulse shorter than one clock. They also assume that the block starts under reset, so every in-service bit starts with a matching route and an enabled, pending source. The bench changes inputs and access fields only at the falling edge and makes one access at a time. It lets every change settle for two clocks before it samples the outputs, so no rise and clear of the same interrupt land on the same edge.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned NODE_WORDS = 4;
  localparam int unsigned PIN_COUNT  = 4;

  // word address regions
  localparam logic [7:0] CFG_ADDR  = 8'h00;
  localparam logic [7:0] EN_BASE   = 8'h08;
  localparam logic [7:0] PIN_BASE  = 8'h10;
  localparam logic [7:0] BNC_BASE  = 8'h18;
  localparam logic [7:0] NODE_BASE = 8'h20;
  localparam logic [7:0] ST_BASE   = 8'h28;
  localparam logic [7:0] RAW_BASE  = 8'h30;
  localparam logic [7:0] CMAP_BASE = 8'h40;

  // position of the lowest set bit, 8 when the byte is zero
  function automatic logic [3:0] low_bit_pos(input logic [7:0] b);
    logic [3:0] pos;
    pos = 4'd8;
    for (int k = 7; k >= 0; k--) begin
      if (b[k]) pos = 4'(k);
    end
    return pos;
  endfunction

  function automatic logic [1:0] pick_pin(input logic [7:0] b);
    logic [3:0] pos;
    pos = low_bit_pos(b);
    return (pos < 4'd4) ? pos[1:0] : 2'd0;
  endfunction

  function automatic logic [7:0] core_pick(input logic [7:0] b, input logic direct);
    logic [3:0] pos;
    pos = low_bit_pos(b);
    if (direct)           return b;
    else if (pos < 4'd4)  return {6'd0, pos[1:0]};
    else                  return 8'd0;
  endfunction

endpackage

// File: rtl/extirq_regs.sv
module extirq_regs
  import extirq_pkg::*;
#(
  parameter int unsigned NUM_IRQ  = 64,
  parameter int unsigned NUM_CORE = 3,
  localparam int unsigned CORE_W  = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1,
  localparam int unsigned NBLK    = NUM_IRQ / 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              acc_en,
  input  logic                              acc_we,
  input  logic [ADDR_W-1:0]                 acc_addr,
  input  logic [31:0]                       acc_wdata,
  input  logic [7:0]                        acc_core,
  input  logic [NUM_IRQ-1:0]                raw_q,
  input  logic [NUM_CORE-1:0][NUM_IRQ-1:0]  status_q,
  output logic [NUM_IRQ-1:0]                en_q,
  output logic [NUM_IRQ-1:0]                en_d,
  output logic [NUM_IRQ-1:0][CORE_W-1:0]    route_q,
  output logic [NUM_IRQ-1:0][CORE_W-1:0]    route_d,
  output logic [NBLK-1:0][1:0]              pin_sel,
  output logic [NUM_IRQ-1:0]                w1c_mask,
  output logic [7:0]                        w1c_core,
  output logic [31:0]                       acc_rdata
);

  localparam int unsigned CMAP_WORDS = NUM_IRQ / 4;

  logic                         wr;
  logic                         rd;
  logic                         direct_q;
  logic [NBLK-1:0][7:0]         pin_q;
  logic [NBLK-1:0][31:0]        bnc_q;
  logic [NODE_WORDS-1:0][31:0]  node_q;
  logic [CMAP_WORDS-1:0][31:0]  cmap_q;
  logic [31:0]                  rd_mux;

  assign wr = acc_en & acc_we;
  assign rd = acc_en & ~acc_we;

  // next enable vector
  always_comb begin
    en_d = en_q;
    for (int w = 0; w < NBLK; w++) begin
      if (wr && acc_addr == 8'(EN_BASE + w)) en_d[w*32 +: 32] = acc_wdata;
    end
  end

  // write-one-to-clear request for the issuing core
  always_comb begin
    w1c_mask = '0;
    for (int w = 0; w < NBLK; w++) begin
      if (wr && acc_addr == 8'(ST_BASE + w)) w1c_mask[w*32 +: 32] = acc_wdata;
    end
  end
  assign w1c_core = acc_core;

  // next decoded route, invalid cores leave the route alone
  always_comb begin
    logic [7:0] cand;
    route_d = route_q;
    for (int i = 0; i < NUM_IRQ; i++) begin
      cand = core_pick(acc_wdata[8*(i%4) +: 8], direct_q);
      if (wr && acc_addr == 8'(CMAP_BASE + i/4) && cand < 8'(NUM_CORE))
        route_d[i] = cand[CORE_W-1:0];
    end
  end

  // pin group decode per 32-block
  generate
    for (genvar j = 0; j < NBLK; j++) begin : g_pin
      assign pin_sel[j] = pick_pin(pin_q[j]);
    end
  endgenerate

  // storage
  always_ff @(posedge clk) begin
    if (rst) begin
      direct_q <= 1'b0;
      en_q     <= '0;
      route_q  <= '0;
      pin_q    <= '0;
      bnc_q    <= '0;
      node_q   <= '0;
      cmap_q   <= '0;
    end else begin
      en_q    <= en_d;
      route_q <= route_d;
      if (wr) begin
        if (acc_addr == CFG_ADDR) direct_q <= acc_wdata[0];
        for (int j = 0; j < NBLK; j++) begin
          if (acc_addr == 8'(PIN_BASE + j/4)) pin_q[j] <= acc_wdata[8*(j%4) +: 8];
          if (acc_addr == 8'(BNC_BASE + j))   bnc_q[j] <= acc_wdata;
        end
        for (int n = 0; n < NODE_WORDS; n++) begin
          if (acc_addr == 8'(NODE_BASE + n)) node_q[n] <= acc_wdata;
        end
        for (int w = 0; w < CMAP_WORDS; w++) begin
          if (acc_addr == 8'(CMAP_BASE + w)) cmap_q[w] <= acc_wdata;
        end
      end
    end
  end

  // read selection
  always_comb begin
    rd_mux = '0;
    if (acc_addr == CFG_ADDR) rd_mux = {31'd0, direct_q};
    for (int j = 0; j < NBLK; j++) begin
      if (acc_addr == 8'(EN_BASE + j))    rd_mux = en_q[j*32 +: 32];
      if (acc_addr == 8'(RAW_BASE + j))   rd_mux = raw_q[j*32 +: 32];
      if (acc_addr == 8'(BNC_BASE + j))   rd_mux = bnc_q[j];
      if (acc_addr == 8'(PIN_BASE + j/4)) rd_mux[8*(j%4) +: 8] = pin_q[j];
      for (int c = 0; c < NUM_CORE; c++) begin
        if (acc_addr == 8'(ST_BASE + j) && acc_core == 8'(c))
          rd_mux = status_q[c][j*32 +: 32];
      end
    end
    for (int n = 0; n < NODE_WORDS; n++) begin
      if (acc_addr == 8'(NODE_BASE + n)) rd_mux = node_q[n];
    end
    for (int w = 0; w < CMAP_WORDS; w++) begin
      if (acc_addr == 8'(CMAP_BASE + w)) rd_mux = cmap_q[w];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     acc_rdata <= '0;
    else if (rd) acc_rdata <= rd_mux;
  end

endmodule

// File: rtl/extirq_status.sv
module extirq_status #(
  parameter int unsigned NUM_IRQ  = 64,
  parameter int unsigned NUM_CORE = 3,
  localparam int unsigned CORE_W  = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_IRQ-1:0]                irq_in,
  input  logic [NUM_IRQ-1:0]                en_q,
  input  logic [NUM_IRQ-1:0]                en_d,
  input  logic [NUM_IRQ-1:0][CORE_W-1:0]    route_q,
  input  logic [NUM_IRQ-1:0][CORE_W-1:0]    route_d,
  input  logic [NUM_IRQ-1:0]                w1c_mask,
  input  logic [7:0]                        w1c_core,
  output logic [NUM_IRQ-1:0]                raw_q,
  output logic [NUM_CORE-1:0][NUM_IRQ-1:0]  status_q
);

  logic [NUM_IRQ-1:0]               rise;
  logic [NUM_IRQ-1:0]               fall;
  logic [NUM_IRQ-1:0]               moved;
  logic [NUM_IRQ-1:0]               masked;
  logic [NUM_IRQ-1:0]               replay;
  logic [NUM_CORE-1:0][NUM_IRQ-1:0] clr;
  logic [NUM_CORE-1:0][NUM_IRQ-1:0] set;

  assign rise   = irq_in & ~raw_q;
  assign fall   = raw_q & ~irq_in;
  assign masked = en_q & ~en_d;

  generate
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
      assign moved[i]  = (route_d[i] != route_q[i]);
      // an already pending source is re-delivered when unmasked or moved
      assign replay[i] = raw_q[i] & irq_in[i] & (~en_q[i] | moved[i]);
      for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        assign clr[c][i] = fall[i] | masked[i]
                         | (w1c_mask[i] & (w1c_core == 8'(c)))
                         | (moved[i] & (route_q[i] == CORE_W'(c)));
        assign set[c][i] = (route_d[i] == CORE_W'(c)) & en_d[i]
                         & (rise[i] | replay[i]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q    <= '0;
      status_q <= '0;
    end else begin
      raw_q <= irq_in;
      for (int c = 0; c < NUM_CORE; c++) begin
        status_q[c] <= (status_q[c] & ~clr[c]) | set[c];
      end
    end
  end

endmodule

// File: rtl/extirq_pin_merge.sv
module extirq_pin_merge #(
  parameter int unsigned NUM_IRQ  = 64,
  parameter int unsigned NUM_CORE = 3,
  localparam int unsigned NBLK    = NUM_IRQ / 32
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [NUM_CORE-1:0][NUM_IRQ-1:0]  status_q,
  input  logic [NBLK-1:0][1:0]              pin_sel,
  output logic [NUM_CORE*4-1:0]             core_irq
);

  logic [3:0][NUM_IRQ-1:0]  grp;
  logic [NUM_CORE*4-1:0]    hot_d;

  generate
    for (genvar p = 0; p < 4; p++) begin : g_pin
      for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        assign grp[p][i] = (pin_sel[i/32] == 2'(p));
      end
      for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        assign hot_d[c*4 + p] = |(status_q[c] & grp[p]);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) core_irq <= '0;
    else     core_irq <= hot_d;
  end

endmodule

// File: rtl/extirq_router.sv
module extirq_router
  import extirq_pkg::*;
#(
  parameter int unsigned NUM_IRQ  = 64,
  parameter int unsigned NUM_CORE = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_IRQ-1:0]     irq_in,
  input  logic                   acc_en,
  input  logic                   acc_we,
  input  logic [7:0]             acc_addr,
  input  logic [31:0]            acc_wdata,
  input  logic [7:0]             acc_core,
  output logic [31:0]            acc_rdata,
  output logic [NUM_CORE*4-1:0]  core_irq
);

  localparam int unsigned CORE_W = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1;
  localparam int unsigned NBLK   = NUM_IRQ / 32;

  logic [NUM_IRQ-1:0]               raw_q;
  logic [NUM_CORE-1:0][NUM_IRQ-1:0] status_q;
  logic [NUM_IRQ-1:0]               en_q;
  logic [NUM_IRQ-1:0]               en_d;
  logic [NUM_IRQ-1:0][CORE_W-1:0]   route_q;
  logic [NUM_IRQ-1:0][CORE_W-1:0]   route_d;
  logic [NBLK-1:0][1:0]             pin_sel;
  logic [NUM_IRQ-1:0]               w1c_mask;
  logic [7:0]                       w1c_core;

  extirq_regs #(.NUM_IRQ(NUM_IRQ), .NUM_CORE(NUM_CORE)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .acc_en    (acc_en),
    .acc_we    (acc_we),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_core  (acc_core),
    .raw_q     (raw_q),
    .status_q  (status_q),
    .en_q      (en_q),
    .en_d      (en_d),
    .route_q   (route_q),
    .route_d   (route_d),
    .pin_sel   (pin_sel),
    .w1c_mask  (w1c_mask),
    .w1c_core  (w1c_core),
    .acc_rdata (acc_rdata)
  );

  extirq_status #(.NUM_IRQ(NUM_IRQ), .NUM_CORE(NUM_CORE)) u_status (
    .clk      (clk),
    .rst      (rst),
    .irq_in   (irq_in),
    .en_q     (en_q),
    .en_d     (en_d),
    .route_q  (route_q),
    .route_d  (route_d),
    .w1c_mask (w1c_mask),
    .w1c_core (w1c_core),
    .raw_q    (raw_q),
    .status_q (status_q)
  );

  extirq_pin_merge #(.NUM_IRQ(NUM_IRQ), .NUM_CORE(NUM_CORE)) u_merge (
    .clk      (clk),
    .rst      (rst),
    .status_q (status_q),
    .pin_sel  (pin_sel),
    .core_irq (core_irq)
  );

endmodule

// File: rtl/extirq_router_chk.sv
module extirq_router_chk #(
  parameter int unsigned NUM_IRQ  = 64,
  parameter int unsigned NUM_CORE = 3,
  localparam int unsigned CORE_W  = (NUM_CORE > 1) ? $clog2(NUM_CORE) : 1
) (
  input logic                              clk,
  input logic                              rst,
  input logic [NUM_IRQ-1:0]                irq_in,
  input logic [NUM_IRQ-1:0]                raw_q,
  input logic [NUM_IRQ-1:0]                en_q,
  input logic [NUM_CORE-1:0][NUM_IRQ-1:0]  status_q,
  input logic [NUM_IRQ-1:0][CORE_W-1:0]    route_q,
  input logic [NUM_CORE*4-1:0]             core_irq,
  input logic [31:0]                       acc_rdata
);

  // R11: reset leaves outputs and read data low
  assert_reset_quiet_R11: assert property (@(posedge clk)
    rst |=> (core_irq == '0 && acc_rdata == '0));

  // R1: raw pending tracks the input one clock later
  assert_raw_track_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> raw_q == $past(irq_in));

  generate
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
      // R2, R5: no in-service bit without its enable
      assert_masked_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (status_q[c] & ~en_q) == '0);
      // R4: an in-service bit needs a live source
      assert_live_source_R4: assert property (@(posedge clk) disable iff (rst)
        (status_q[c] & ~raw_q) == '0);
      // R4: a core with nothing in service drives all its pins low next cycle
      assert_idle_core_R4: assert property (@(posedge clk) disable iff (rst)
        (status_q[c] == '0) |=> (core_irq[c*4 +: 4] == 4'd0));
      for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        // R10: in-service bits live only at the current route
        assert_route_home_R10: assert property (@(posedge clk) disable iff (rst)
          status_q[c][i] |-> (route_q[i] == CORE_W'(c)));
      end
    end
  endgenerate

endmodule

bind extirq_router extirq_router_chk #(.NUM_IRQ(NUM_IRQ), .NUM_CORE(NUM_CORE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq_in    (irq_in),
  .raw_q     (raw_q),
  .en_q      (en_q),
  .status_q  (status_q),
  .route_q   (route_q),
  .core_irq  (core_irq),
  .acc_rdata (acc_rdata)
);

// File: tb/extirq_router_test.sv
module extirq_router_test;

  localparam int unsigned NI = 64;
  localparam int unsigned NC = 3;

  localparam logic [7:0] A_CFG  = 8'h00;
  localparam logic [7:0] A_EN   = 8'h08;
  localparam logic [7:0] A_PIN  = 8'h10;
  localparam logic [7:0] A_BNC  = 8'h18;
  localparam logic [7:0] A_NODE = 8'h20;
  localparam logic [7:0] A_ST   = 8'h28;
  localparam logic [7:0] A_RAW  = 8'h30;
  localparam logic [7:0] A_CMAP = 8'h40;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NI-1:0]   irq_in = '0;
  logic            acc_en = 1'b0;
  logic            acc_we = 1'b0;
  logic [7:0]      acc_addr = '0;
  logic [31:0]     acc_wdata = '0;
  logic [7:0]      acc_core = '0;
  logic [31:0]     acc_rdata;
  logic [NC*4-1:0] core_irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  extirq_router #(.NUM_IRQ(NI), .NUM_CORE(NC)) uut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .acc_en(acc_en), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_core(acc_core),
    .acc_rdata(acc_rdata), .core_irq(core_irq)
  );

  task automatic expect_eq(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [7:0] core);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d; acc_core = core;
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] core, output logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_we = 1'b0; acc_addr = a; acc_core = core;
    @(negedge clk);
    acc_en = 1'b0;
    d = acc_rdata;
  endtask

  function automatic logic [31:0] line(input int core, input int pin);
    return 32'd1 << (core * 4 + pin);
  endfunction

  function automatic int exp_pin(input logic [7:0] b);
    for (int k = 0; k < 4; k++) if (b[k]) return k;
    return 0;
  endfunction

  function automatic logic [31:0] w1_off(input logic [7:0] b5);
    return {8'h02, 8'h01, b5, 8'h02};
  endfunction

  function automatic logic [31:0] w1_dir(input logic [7:0] b5);
    return {8'h01, 8'h00, b5, 8'h01};
  endfunction

  task automatic set_route5(input logic [31:0] word, input int core, input string req);
    wr(A_CMAP + 8'd1, word, 8'd0);
    idle(2);
    expect_eq(req, "irq5 output line", {20'd0, core_irq}, line(core, 1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R11: reset state
    expect_eq("R11", "outputs after reset", {20'd0, core_irq}, 32'd0);
    rd(A_EN, 8'd0, d);       expect_eq("R11", "enable word 0", d, 32'd0);
    rd(A_CMAP, 8'd0, d);     expect_eq("R11", "core map word 0", d, 32'd0);

    // block 0 -> pin 1, block 1 -> pin 3; irq i -> core i%3
    wr(A_PIN, 32'h0000_0802, 8'd0);
    for (int w = 0; w < NI / 4; w++) begin
      logic [31:0] word;
      for (int k = 0; k < 4; k++) word[8*k +: 8] = 8'(1 << ((4*w + k) % 3));
      wr(A_CMAP + 8'(w), word, 8'd0);
    end

    // sweep every interrupt through raise, unmask, clear, lower
    for (int i = 0; i < NI; i++) begin
      int c, p, oc;
      logic [7:0] wi;
      c  = i % 3;
      p  = (i < 32) ? 1 : 3;
      oc = (c + 1) % 3;
      wi = 8'(i / 32);
      irq_in[i] = 1'b1;
      idle(2);
      expect_eq("R2", "disabled rise output", {20'd0, core_irq}, 32'd0);
      rd(A_RAW + wi, 8'd0, d);
      expect_eq("R1", "raw word", d, 32'd1 << (i % 32));
      wr(A_EN + wi, 32'd1 << (i % 32), 8'd0);
      idle(2);
      expect_eq("R5", "unmask pending output", {20'd0, core_irq}, line(c, p));
      rd(A_ST + wi, 8'(c), d);
      expect_eq("R13", "own in-service word", d, 32'd1 << (i % 32));
      rd(A_ST + wi, 8'(oc), d);
      expect_eq("R13", "other core in-service word", d, 32'd0);
      wr(A_ST + wi, 32'hFFFF_FFFF, 8'(oc));
      idle(2);
      expect_eq("R6", "clear from other core", {20'd0, core_irq}, line(c, p));
      wr(A_ST + wi, 32'd1 << (i % 32), 8'(c));
      idle(2);
      expect_eq("R6", "clear from owning core", {20'd0, core_irq}, 32'd0);
      irq_in[i] = 1'b0;
      wr(A_EN + wi, 32'd0, 8'd0);
    end

    // R3 and R4: enabled rise, shared line held by the last source
    wr(A_EN, 32'h0000_0009, 8'd0);
    irq_in[0] = 1'b1; idle(2);
    expect_eq("R3", "enabled rise irq0", {20'd0, core_irq}, line(0, 1));
    irq_in[3] = 1'b1; idle(2);
    expect_eq("R4", "two sources", {20'd0, core_irq}, line(0, 1));
    irq_in[0] = 1'b0; idle(2);
    expect_eq("R4", "one source left", {20'd0, core_irq}, line(0, 1));
    irq_in[3] = 1'b0; idle(2);
    expect_eq("R4", "last source gone", {20'd0, core_irq}, 32'd0);
    irq_in[3] = 1'b1; idle(2);
    expect_eq("R3", "enabled rise irq3", {20'd0, core_irq}, line(0, 1));
    wr(A_EN, 32'h0000_0001, 8'd0); idle(2);
    expect_eq("R5", "mask pending", {20'd0, core_irq}, 32'd0);
    wr(A_EN, 32'h0000_0009, 8'd0); idle(2);
    expect_eq("R5", "unmask pending again", {20'd0, core_irq}, line(0, 1));
    irq_in[3] = 1'b0;
    wr(A_EN, 32'd0, 8'd0);

    // R7: every pin byte value for block 0
    wr(A_EN, 32'h0000_0001, 8'd0);
    irq_in[0] = 1'b1;
    for (int b = 0; b < 256; b++) begin
      wr(A_PIN, {16'd0, 8'h08, 8'(b)}, 8'd0);
      idle(1);
      expect_eq("R7", $sformatf("pin byte %02h", b), {20'd0, core_irq}, line(0, exp_pin(8'(b))));
    end
    rd(A_PIN, 8'd0, d);
    expect_eq("R12", "pin word readback", d, 32'h0000_08FF);
    wr(A_PIN, 32'h0000_0802, 8'd0);
    irq_in[0] = 1'b0;
    wr(A_EN, 32'd0, 8'd0);

    // R8, R9, R10: re-routing pending irq5 (core 2, pin 1)
    wr(A_EN, 32'h0000_0020, 8'd0);
    irq_in[5] = 1'b1; idle(2);
    expect_eq("R3", "irq5 start", {20'd0, core_irq}, line(2, 1));
    set_route5(w1_off(8'h02), 1, "R10");
    rd(A_ST, 8'd1, d);
    expect_eq("R10", "in-service moved to core1", d, 32'h0000_0020);
    rd(A_ST, 8'd2, d);
    expect_eq("R10", "in-service left core2", d, 32'd0);
    set_route5(w1_off(8'h30), 0, "R8");
    set_route5(w1_off(8'h04), 2, "R8");
    set_route5(w1_off(8'h00), 0, "R8");
    set_route5(w1_off(8'h08), 0, "R9");
    rd(A_CMAP + 8'd1, 8'd0, d);
    expect_eq("R12", "core map readback", d, w1_off(8'h08));
    wr(A_CFG, 32'hFFFF_FFFF, 8'd0);
    rd(A_CFG, 8'd0, d);
    expect_eq("R12", "mode word readback", d, 32'd1);
    set_route5(w1_dir(8'h02), 2, "R8");
    set_route5(w1_dir(8'h03), 2, "R9");
    set_route5(w1_dir(8'h01), 1, "R8");
    wr(A_CFG, 32'd0, 8'd0);
    set_route5(w1_off(8'h04), 2, "R8");
    irq_in[5] = 1'b0; idle(2);
    expect_eq("R4", "irq5 lowered", {20'd0, core_irq}, 32'd0);
    wr(A_EN, 32'd0, 8'd0);

    // R12: plain storage words
    wr(A_BNC + 8'd1, 32'hA5A5_0F0F, 8'd0);
    wr(A_NODE + 8'd3, 32'h1234_5678, 8'd0);
    rd(A_BNC + 8'd1, 8'd0, d);   expect_eq("R12", "spare word", d, 32'hA5A5_0F0F);
    rd(A_NODE + 8'd3, 8'd0, d);  expect_eq("R12", "node word", d, 32'h1234_5678);
    expect_eq("R12", "storage writes leave outputs", {20'd0, core_irq}, 32'd0);

    // R11: reset in the middle of activity
    wr(A_EN + 8'd1, 32'h0000_0001, 8'd0);
    irq_in[32] = 1'b1; idle(2);
    expect_eq("R3", "irq32 before reset", {20'd0, core_irq}, line(2, 3));
    rst = 1'b1; idle(2); rst = 1'b0; idle(1);
    expect_eq("R11", "outputs after mid reset", {20'd0, core_irq}, 32'd0);
    rd(A_EN + 8'd1, 8'd0, d);    expect_eq("R11", "enable cleared", d, 32'd0);
    rd(A_BNC + 8'd1, 8'd0, d);   expect_eq("R11", "spare word cleared", d, 32'd0);
    irq_in[32] = 1'b0;
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule